// File: doc/BRIEF.md
# Single-slope PWM timer with buffered compare

This block is an up-counting timer that drives two pulse-width-modulated outputs. A prescaler turns the input clock into a timer tick. On every tick the counter steps up by one. When the counter equals the period limit (TOP), the next tick clears it to zero and sets a sticky overflow flag. TOP is taken either from a period register, which takes effect as soon as it is written, or from the active compare value of channel A.

Each channel has a compare value that software can write at any moment. A write lands in a shadow copy, and reading the channel returns that shadow copy. The shadow copy becomes the active compare value only on the tick that wraps the counter at TOP, so a new duty cycle always starts on a period boundary.

A channel can be switched off, run in non-inverted PWM mode or run in inverted PWM mode. Channel A can also toggle on each compare match, which gives a 50% square wave.

Top module: `slope_pwm_timer`

## Requirements
- R1: On a tick with the count equal to TOP, the counter becomes 0 and the overflow flag becomes 1 in the same cycle. On any other tick the count rises by one. After reset the count, the flag, both outputs and both compare read-backs are 0.
- R2: When `topFromA` is 0, TOP is the period register, and a period write takes effect on the next clock. When `topFromA` is 1, TOP is the active compare value of channel A, and the period register is ignored.
- R3: A compare write stores `wrData` in that channel's shadow register, and the read port shows it on the next clock. The active value changes only on a tick that wraps the counter at TOP. A write made mid-period leaves that period's duty unchanged and applies from the next period.
- R4: If the period is written below the current count, the counter runs on to 0xFFFF and rolls over to 0. That roll-over does not set the overflow flag. The next wrap at TOP does set it.
- R5: Mode code 2 (non-inverted) sets the output on the wrap tick and clears it on the tick where the count equals the active compare value C. The output is high for C+1 of every TOP+1 ticks.
- R6: Mode code 3 (inverted) gives the complement of mode 2. The output is low for C+1 of every TOP+1 ticks.
- R7: With C = 0, mode 2 gives a one-tick high spike per period. With C = TOP, the output stays high in mode 2 and stays low in mode 3. In mode 3 with C = 0, the output is high for TOP ticks per period.
- R8: Mode code 1 on channel A toggles the output on each compare match, but only while `topFromA` is 1. This gives TOP+1 high ticks in every 2*(TOP+1) ticks. Mode code 1 on channel B, or on channel A while `topFromA` is 0, holds the output low.
- R9: Mode code 0 holds the output low.
- R10: The prescaler select codes are: 1 divides by 1, 2 by 8, 3 by 64, 4 by 256 and 5 by 1024. Codes 0, 6 and 7 stop the counter. Any change of the select restarts the prescale count, so the first tick after a change to divide-by-N comes N+1 clocks after the change.
- R11: The overflow flag stays set until `ovfClear` is 1 on a cycle with no wrap. If a clear and a wrap fall on the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 16 | Write data for the period and compare registers |
| wrPeriod | input | 1 | Write strobe for the period register |
| wrCmpA | input | 1 | Write strobe for the channel A shadow compare register |
| wrCmpB | input | 1 | Write strobe for the channel B shadow compare register |
| ovfClear | input | 1 | Write-one-to-clear strobe for the overflow flag |
| modeA | input | 2 | Channel A output mode (0 off, 1 toggle, 2 PWM, 3 inverted PWM) |
| modeB | input | 2 | Channel B output mode (0 off, 1 off, 2 PWM, 3 inverted PWM) |
| topFromA | input | 1 | TOP source: 0 is the period register, 1 is the channel A active compare |
| preSel | input | 3 | Prescaler select |
| waveA | output | 1 | Channel A waveform |
| waveB | output | 1 | Channel B waveform |
| ovfFlag | output | 1 | Sticky overflow flag |
| count | output | 16 | Live counter value |
| cmpARead | output | 16 | Channel A shadow compare contents |
| cmpBRead | output | 16 | Channel B shadow compare contents |

## Verification
The assertions take for granted that the write strobes, `wrData` and the mode and select inputs change only between clock edges. They also take for granted that a change of prescaler select is followed by at least one clock at the new value before the restart can be judged. The bench drives every input on the falling edge and holds each select value for many clocks. It starts each scenario from reset with the prescaler stopped while it loads the registers, so that every measured period begins from a known count. The waveform checks open their window just after a wrap at TOP, when the newly loaded compare values are already active.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [1:0] {
    OUT_OFF     = 2'd0,
    OUT_TOGGLE  = 2'd1,
    OUT_PWM     = 2'd2,
    OUT_PWM_INV = 2'd3
  } outMode_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic tick;     // timer tick from the prescaler
    logic pwmA;     // channel A is in a PWM mode
    logic invA;     // channel A PWM is inverted
    logic toggleA;  // channel A is in a valid toggle mode
    logic pwmB;     // channel B is in a PWM mode
    logic invB;     // channel B PWM is inverted
  } strobe_t;

endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] preSel,
  input  logic [1:0] modeA,
  input  logic [1:0] modeB,
  input  logic       topFromA,
  output strobe_t    strobe
);

  localparam int DIV_W = PRE_W + 1;

  function automatic logic [DIV_W-1:0] divFor(input logic [2:0] sel);
    case (sel)
      3'd1:    divFor = DIV_W'(1);
      3'd2:    divFor = DIV_W'(1) << 3;
      3'd3:    divFor = DIV_W'(1) << 6;
      3'd4:    divFor = DIV_W'(1) << 8;
      3'd5:    divFor = DIV_W'(1) << PRE_W;
      default: divFor = '0;
    endcase
  endfunction

  logic [PRE_W-1:0] preCnt;
  logic [2:0]       preSelQ;
  logic [DIV_W-1:0] divisor;
  logic             running;
  logic             selChange;
  logic             preHit;
  outMode_e         modeAE;
  outMode_e         modeBE;

  assign divisor   = divFor(preSel);
  assign running   = (divisor != '0);
  assign selChange = (preSel != preSelQ);
  assign preHit    = running && ({1'b0, preCnt} == divisor - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      preSelQ <= '0;
    end else begin
      preSelQ <= preSel;
      if (selChange || !running || preHit) preCnt <= '0;
      else                                 preCnt <= preCnt + 1'b1;
    end
  end

  assign modeAE = outMode_e'(modeA);
  assign modeBE = outMode_e'(modeB);

  always_comb begin
    strobe.tick    = preHit && !selChange;
    strobe.pwmA    = (modeAE == OUT_PWM) || (modeAE == OUT_PWM_INV);
    strobe.invA    = (modeAE == OUT_PWM_INV);
    strobe.toggleA = (modeAE == OUT_TOGGLE) && topFromA;
    strobe.pwmB    = (modeBE == OUT_PWM) || (modeBE == OUT_PWM_INV);
    strobe.invB    = (modeBE == OUT_PWM_INV);
  end

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> (!strobe.tick || preSel == 3'd1)); // R10

endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrPeriod,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic             topFromA,
  input  logic             ovfClear,
  output logic             waveA,
  output logic             waveB,
  output logic             ovfFlag,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpARead,
  output logic [CNT_W-1:0] cmpBRead
);

  logic [CNT_W-1:0] cnt, period, bufA, bufB, actA, actB, top;
  logic atTop, wrapTick, matchA, matchB;
  logic pwmAQ, pwmBQ, togAQ, ovfQ;

  assign top      = topFromA ? actA : period;
  assign atTop    = (cnt == top);
  assign wrapTick = strobe.tick && atTop;
  assign matchA   = strobe.tick && (cnt == actA);
  assign matchB   = strobe.tick && (cnt == actB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      period <= '0;
      bufA   <= '0;
      bufB   <= '0;
      actA   <= '0;
      actB   <= '0;
      ovfQ   <= 1'b0;
    end else begin
      if (wrPeriod) period <= wrData;
      if (wrCmpA)   bufA   <= wrData;
      if (wrCmpB)   bufB   <= wrData;
      if (strobe.tick) begin
        if (atTop) begin
          cnt  <= '0;
          actA <= bufA;
          actB <= bufB;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (wrapTick)      ovfQ <= 1'b1;
      else if (ovfClear) ovfQ <= 1'b0;
    end
  end

  // Waveform state: a wrap sets, a compare match clears, and the wrap wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmAQ <= 1'b0;
      pwmBQ <= 1'b0;
      togAQ <= 1'b0;
    end else begin
      if (wrapTick)    pwmAQ <= 1'b1;
      else if (matchA) pwmAQ <= 1'b0;
      if (wrapTick)    pwmBQ <= 1'b1;
      else if (matchB) pwmBQ <= 1'b0;
      if (matchA && strobe.toggleA) togAQ <= ~togAQ;
    end
  end

  assign waveA    = strobe.toggleA ? togAQ :
                    strobe.pwmA    ? (pwmAQ ^ strobe.invA) : 1'b0;
  assign waveB    = strobe.pwmB ? (pwmBQ ^ strobe.invB) : 1'b0;
  assign ovfFlag  = ovfQ;
  assign count    = cnt;
  assign cmpARead = bufA;
  assign cmpBRead = bufB;

  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    wrapTick |=> (count == '0 && ovfFlag)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(count)); // R10

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrapTick |=> ($stable(actA) && $stable(actB))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag); // R11

  AST_MAX_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !atTop && cnt == '1) |=> (count == '0)); // R4

endmodule

// File: rtl/slope_pwm_timer.sv
module slope_pwm_timer
  import spt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrPeriod,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic             ovfClear,
  input  logic [1:0]       modeA,
  input  logic [1:0]       modeB,
  input  logic             topFromA,
  input  logic [2:0]       preSel,
  output logic             waveA,
  output logic             waveB,
  output logic             ovfFlag,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpARead,
  output logic [CNT_W-1:0] cmpBRead
);

  strobe_t strobe;

  spt_ctrl #(.PRE_W(PRE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .preSel   (preSel),
    .modeA    (modeA),
    .modeB    (modeB),
    .topFromA (topFromA),
    .strobe   (strobe)
  );

  spt_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .wrPeriod (wrPeriod),
    .wrCmpA   (wrCmpA),
    .wrCmpB   (wrCmpB),
    .topFromA (topFromA),
    .ovfClear (ovfClear),
    .waveA    (waveA),
    .waveB    (waveB),
    .ovfFlag  (ovfFlag),
    .count    (count),
    .cmpARead (cmpARead),
    .cmpBRead (cmpBRead)
  );

endmodule

// File: tb/test_slope_pwm_timer.sv
module test_slope_pwm_timer;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [15:0] wrData;
  logic        wrPeriod, wrCmpA, wrCmpB, ovfClear, topFromA;
  logic [1:0]  modeA, modeB;
  logic [2:0]  preSel;
  logic        waveA, waveB, ovfFlag;
  logic [15:0] count, cmpARead, cmpBRead;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  slope_pwm_timer i_slope_pwm_timer (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrPeriod(wrPeriod),
    .wrCmpA(wrCmpA), .wrCmpB(wrCmpB), .ovfClear(ovfClear),
    .modeA(modeA), .modeB(modeB), .topFromA(topFromA), .preSel(preSel),
    .waveA(waveA), .waveB(waveB), .ovfFlag(ovfFlag), .count(count),
    .cmpARead(cmpARead), .cmpBRead(cmpBRead)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int which, int val);
    wrData = 16'(val);
    case (which)
      0: wrPeriod = 1'b1;
      1: wrCmpA   = 1'b1;
      default: wrCmpB = 1'b1;
    endcase
    step(1);
    wrPeriod = 1'b0; wrCmpA = 1'b0; wrCmpB = 1'b0;
  endtask

  task automatic setup(int per, int a, int b, int mA, int mB, bit tA, int sel);
    rstN = 1'b0; wrData = '0; wrPeriod = 0; wrCmpA = 0; wrCmpB = 0;
    ovfClear = 0; topFromA = 0; modeA = '0; modeB = '0; preSel = '0;
    step(2);
    rstN = 1'b1;
    step(1);
    wr(0, per); wr(1, a); wr(2, b);
    modeA = 2'(mA); modeB = 2'(mB); topFromA = tA; preSel = 3'(sel);
  endtask

  // Returns on the first sample after a wrap at the given TOP.
  task automatic syncTop(int top);
    int guard = 0;
    step(3);
    while (count != 16'(top) && guard < 5000) begin step(1); guard++; end
    step(1);
  endtask

  task automatic highs(int n, output int hA, output int hB);
    hA = 0; hB = 0;
    for (int i = 0; i < n; i++) begin
      if (waveA) hA++;
      if (waveB) hB++;
      step(1);
    end
  endtask

  task automatic waitChange(output int n);
    logic [15:0] v = count;
    n = 0;
    do begin step(1); n++; end while (count == v && n < 3000);
  endtask

  task automatic testReset();
    setup(0, 0, 0, 0, 0, 0, 0);
    chk("R1 reset count", count, 0);
    chk("R1 reset flag", ovfFlag, 0);
    chk("R1 reset waveA", waveA, 0);
    chk("R1 reset waveB", waveB, 0);
  endtask

  task automatic testNonInverted();
    int hA, hB;
    setup(9, 4, 0, 2, 2, 0, 1);
    syncTop(9);
    chk("R1 wrap to zero", count, 0);
    chk("R1 flag on wrap", ovfFlag, 1);
    highs(10, hA, hB);
    chk("R5 mode2 C=4 highs", hA, 5);
    chk("R7 mode2 C=0 spike", hB, 1);
    chk("R1 period length", count, 0);
  endtask

  task automatic testInverted();
    int hA, hB;
    setup(9, 2, 9, 3, 3, 0, 1);
    syncTop(9);
    highs(10, hA, hB);
    chk("R6 mode3 C=2 highs", hA, 7);
    chk("R7 mode3 C=TOP constant low", hB, 0);
  endtask

  task automatic testExtremes();
    int hA, hB;
    setup(9, 9, 0, 2, 3, 0, 1);
    syncTop(9);
    highs(20, hA, hB);
    chk("R7 mode2 C=TOP constant high", hA, 20);
    chk("R7 mode3 C=0 highs", hB, 18);
  endtask

  task automatic testBuffer();
    int hB;
    setup(20, 0, 10, 0, 2, 0, 1);
    syncTop(20);
    chk("R3 read shows shadow", cmpBRead, 10);
    hB = 0;
    wrData = 16'd15; wrCmpB = 1'b1;
    for (int i = 0; i < 21; i++) begin
      if (waveB) hB++;
      step(1);
      if (i == 0) begin
        wrCmpB = 1'b0;
        chk("R3 read after write", cmpBRead, 15);
      end
    end
    chk("R3 old duty kept mid-period", hB, 11);
    hB = 0;
    for (int i = 0; i < 21; i++) begin
      if (waveB) hB++;
      step(1);
    end
    chk("R3 new duty next period", hB, 16);
  endtask

  task automatic testTopFromA();
    setup(5, 20, 0, 0, 0, 1, 1);
    syncTop(20);
    step(20);
    chk("R2 TOP from channel A reaches 20", count, 20);
    step(1);
    chk("R2 TOP from channel A wraps", count, 0);
    chk("R2 cmpA read", cmpARead, 20);
  endtask

  task automatic testToggle();
    int hA, hB;
    setup(0, 7, 0, 1, 1, 1, 1);
    syncTop(7);
    highs(32, hA, hB);
    chk("R8 toggle 50% duty", hA, 16);
    chk("R8 channel B mode1 low", hB, 0);
    setup(7, 3, 0, 1, 0, 0, 1);
    syncTop(7);
    highs(16, hA, hB);
    chk("R8 toggle without TOP from A low", hA, 0);
  endtask

  task automatic testOff();
    int hA, hB;
    setup(9, 4, 4, 0, 0, 0, 1);
    syncTop(9);
    highs(20, hA, hB);
    chk("R9 mode0 A low", hA, 0);
    chk("R9 mode0 B low", hB, 0);
  endtask

  task automatic testPrescale();
    int n;
    logic [15:0] held;
    setup(1000, 0, 0, 0, 0, 0, 2);
    waitChange(n);
    waitChange(n);
    chk("R10 divide by 8", n, 8);
    preSel = 3'd3;
    waitChange(n);
    chk("R10 switch to 64 restarts", n, 65);
    waitChange(n);
    chk("R10 divide by 64", n, 64);
    step(30);
    preSel = 3'd2;
    waitChange(n);
    chk("R10 mid-count switch to 8", n, 9);
    preSel = 3'd0;
    step(1);
    held = count;
    step(200);
    chk("R10 select 0 stops", count, held);
    preSel = 3'd7;
    step(100);
    chk("R10 select 7 stops", count, held);
    preSel = 3'd1;
    waitChange(n);
    chk("R10 divide by 1 after restart", n, 2);
  endtask

  task automatic testMiss();
    int guard = 0;
    setup(200, 0, 0, 0, 0, 0, 1);
    while (count != 16'd150 && guard < 1000) begin step(1); guard++; end
    wr(0, 50);
    guard = 0;
    while (count != 16'd0 && guard < 70000) begin step(1); guard++; end
    chk("R4 ran past to 0xFFFF", (guard > 65000) ? 1 : 0, 1);
    chk("R4 no flag on rollover", ovfFlag, 0);
    step(50);
    chk("R4 at new TOP", count, 50);
    step(1);
    chk("R4 wrap at new TOP sets flag", ovfFlag, 1);
  endtask

  task automatic testOvf();
    int guard = 0;
    setup(3, 0, 0, 0, 0, 0, 1);
    syncTop(3);
    step(10);
    chk("R11 flag sticky", ovfFlag, 1);
    while (count != 16'd1 && guard < 100) begin step(1); guard++; end
    ovfClear = 1'b1; step(1); ovfClear = 1'b0;
    chk("R11 clear away from wrap", ovfFlag, 0);
    guard = 0;
    while (count != 16'd3 && guard < 100) begin step(1); guard++; end
    ovfClear = 1'b1; step(1); ovfClear = 1'b0;
    chk("R11 set wins over clear", ovfFlag, 1);
    chk("R11 wrap happened", count, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testNonInverted();
    testInverted();
    testExtremes();
    testBuffer();
    testTopFromA();
    testToggle();
    testOff();
    testPrescale();
    testMiss();
    testOvf();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule